// File: doc/BRIEF.md
# Microprogram Sequencer with Loop Counter

This block picks the address of the next microword in a horizontally microcoded processor. Every clock it reads a five-bit sequencing code from the current microword and updates the micro program counter. The choices are to step to the next word, to jump unconditionally, to jump when a chosen flag is set or clear, to call a micro-subroutine or return from one, to halt, to go back to address zero, or to dispatch through one of two small loadable tables. One table is indexed by the opcode nibble of the instruction register and the other by its addressing-mode bits. A single return register holds one return address. The data bus cannot read or write it, and only a call changes it.

A loop counter sits beside the sequencer. The microword can load it with a constant, load it from the bus, or decrement it, and the encoding allows only one of these per cycle. The counter cannot be read. Its zero state leaves the block as the L flag, and the conditional branch codes can test L. Halt parks the counter at address zero and ignores the microword until the start input is raised.

Top module: `microseq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the program counter, the return register, the loop counter and both tables to zero and clears the halted state. After reset `upc_o`=0, `l_flag_o`=1 and `halted_o`=0.
- R2: Code 0 (step) and every unassigned code from 18 to 31 load `upc_o` with its previous value plus one, wrapping at 2^UPC_W.
- R3: Code 1 (jump) loads `upc_o` with `br_addr_i`.
- R4: The conditional codes are 2/3 (Z set/clear), 4/5 (N set/clear), 6/7 (C set/clear) and 8/9 (O set/clear). When the tested condition holds they load `br_addr_i`. Otherwise they step by one.
- R5: Code 12 (call) stores the current `upc_o` plus one in the return register and loads `br_addr_i`. Code 13 (return) loads `upc_o` from the return register.
- R6: Only a call executed while not halted changes the return register, so two returns in a row land on the same address.
- R7: Code 16 (halt) sets `upc_o` to 0 and `halted_o` to 1. While halted and `start_i` is low, `upc_o` stays 0, the sequencing code is ignored and the loop-counter action is ignored.
- R8: While halted, `start_i`=1 clears `halted_o` at the next edge and `upc_o` stays 0. The word at address 0 then executes on the cycle after that.
- R9: Code 17 (restart) sets `upc_o` to 0 and leaves `halted_o` at 0.
- R10: Code 14 loads `upc_o` from the opcode-table entry selected by `ir_i[15:12]`.
- R11: Code 15 loads `upc_o` from the mode-table entry selected by `ir_i[9:8]`.
- R12: With `tbl_we_i`=1, `tbl_data_i` is written at the clock edge. The target is the opcode table at `tbl_idx_i` when `tbl_sel_i`=0, or the mode table at `tbl_idx_i[1:0]` when `tbl_sel_i`=1. A dispatch in the same cycle still reads the old entry. Writes also take effect while halted.
- R13: The loop-counter action `lc_op_i` is 0 hold, 1 load `lc_const_i`, 2 load `bus_i`, or 3 decrement by one (0 wraps to all ones). It applies only while not halted. `l_flag_o` is 1 exactly when the counter is 0.
- R14: Codes 10/11 branch when L is set or clear. The test uses the L value before the same cycle's counter action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Releases the halted state |
| seq_op_i | input | 5 | Sequencing code of the current microword |
| br_addr_i | input | UPC_W | Branch/call target address field |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_c_i | input | 1 | Carry flag |
| flag_o_i | input | 1 | Overflow flag |
| ir_i | input | IR_W | Instruction register |
| lc_op_i | input | 2 | Loop-counter action |
| lc_const_i | input | LC_W | Constant from the microword for the counter |
| bus_i | input | LC_W | Data bus value for the counter |
| tbl_we_i | input | 1 | Table write enable |
| tbl_sel_i | input | 1 | Table select: 0 opcode, 1 mode |
| tbl_idx_i | input | OPC_W | Table write index |
| tbl_data_i | input | UPC_W | Table write data |
| upc_o | output | UPC_W | Micro program counter |
| l_flag_o | output | 1 | Loop counter is zero |
| halted_o | output | 1 | Sequencer is halted |

## Verification
The directed part walks all sixteen opcode entries and all four mode entries with distinct contents, so a wrong index bit or a swapped table gives a wrong address. A call followed by two returns separates a return register that holds its value from one that is disturbed. The counter is stepped through 2, 1, 0 and the wrap to all ones while L is branched on, which shows whether the branch uses the old L or the new one. A halt is issued with jump codes and counter decrements still driven, so that ignored inputs show up on `upc_o` and `l_flag_o`. Random sequencing codes, flags, IR values, table writes and start pulses then mix every transition, including writes made in the same cycle as a dispatch and start pulses that arrive while the block is running.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [4:0] {
        SQ_STEP     = 5'd0,
        SQ_JUMP     = 5'd1,
        SQ_IF_Z     = 5'd2,
        SQ_IF_NZ    = 5'd3,
        SQ_IF_N     = 5'd4,
        SQ_IF_NN    = 5'd5,
        SQ_IF_C     = 5'd6,
        SQ_IF_NC    = 5'd7,
        SQ_IF_O     = 5'd8,
        SQ_IF_NO    = 5'd9,
        SQ_IF_L     = 5'd10,
        SQ_IF_NL    = 5'd11,
        SQ_CALL     = 5'd12,
        SQ_RET      = 5'd13,
        SQ_OPDISP   = 5'd14,
        SQ_MODEDISP = 5'd15,
        SQ_HALT     = 5'd16,
        SQ_RESTART  = 5'd17
    } seq_op_e;

    typedef enum logic [1:0] {
        LC_HOLD  = 2'd0,
        LC_CONST = 2'd1,
        LC_BUS   = 2'd2,
        LC_DEC   = 2'd3
    } lc_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic o;
        logic l;
    } seq_flags_t;

    function automatic logic is_cond(input seq_op_e op);
        return (op >= SQ_IF_Z) && (op <= SQ_IF_NL);
    endfunction

    // Flag pairs: even code tests set, odd code tests clear.
    function automatic logic cond_hit(input seq_op_e op, input seq_flags_t f);
        logic sel;
        case (op)
            SQ_IF_Z,  SQ_IF_NZ: sel = f.z;
            SQ_IF_N,  SQ_IF_NN: sel = f.n;
            SQ_IF_C,  SQ_IF_NC: sel = f.c;
            SQ_IF_O,  SQ_IF_NO: sel = f.o;
            SQ_IF_L,  SQ_IF_NL: sel = f.l;
            default:            sel = 1'b0;
        endcase
        return op[0] ? ~sel : sel;
    endfunction

endpackage

// File: rtl/useq_dtable.sv
module useq_dtable #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

    assert_tbl_write_R12: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(widx)] == $past(wdata));

endmodule

// File: rtl/useq_loopctr.sv
module useq_loopctr
    import useq_pkg::*;
#(
    parameter int LC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  lc_op_e          op,
    input  logic [LC_W-1:0] konst,
    input  logic [LC_W-1:0] bus,
    output logic            zero
);
    localparam logic [LC_W-1:0] LC_ONE = LC_W'(1);

    logic [LC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            case (op)
                LC_CONST: cnt_q <= konst;
                LC_BUS:   cnt_q <= bus;
                LC_DEC:   cnt_q <= cnt_q - LC_ONE;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign zero = (cnt_q == '0);

    assert_lc_dec_R13: assert property (@(posedge clk) disable iff (rst)
        (en && op == LC_DEC) |=> cnt_q == $past(cnt_q) - LC_ONE);

    assert_lc_idle_R13: assert property (@(posedge clk) disable iff (rst)
        (!en || op == LC_HOLD) |=> $stable(cnt_q));

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
#(
    parameter int UPC_W = 8
) (
    input  seq_op_e          op,
    input  seq_flags_t       flags,
    input  logic             halted,
    input  logic             start,
    input  logic [UPC_W-1:0] upc,
    input  logic [UPC_W-1:0] ret_addr,
    input  logic [UPC_W-1:0] br_addr,
    input  logic [UPC_W-1:0] op_tgt,
    input  logic [UPC_W-1:0] mode_tgt,
    output logic [UPC_W-1:0] upc_d,
    output logic             ret_we,
    output logic [UPC_W-1:0] ret_d,
    output logic             halted_d
);
    localparam logic [UPC_W-1:0] UPC_ONE = UPC_W'(1);

    logic [UPC_W-1:0] upc_inc;
    assign upc_inc = upc + UPC_ONE;
    assign ret_d   = upc_inc;

    always_comb begin
        upc_d    = upc_inc;
        ret_we   = 1'b0;
        halted_d = halted;
        if (halted) begin
            upc_d = '0;
            if (start) halted_d = 1'b0;
        end else if (is_cond(op)) begin
            upc_d = cond_hit(op, flags) ? br_addr : upc_inc;
        end else begin
            case (op)
                SQ_JUMP:     upc_d = br_addr;
                SQ_CALL: begin
                    upc_d  = br_addr;
                    ret_we = 1'b1;
                end
                SQ_RET:      upc_d = ret_addr;
                SQ_OPDISP:   upc_d = op_tgt;
                SQ_MODEDISP: upc_d = mode_tgt;
                SQ_HALT: begin
                    upc_d    = '0;
                    halted_d = 1'b1;
                end
                SQ_RESTART:  upc_d = '0;
                default:     upc_d = upc_inc;
            endcase
        end
    end

endmodule

// File: rtl/microseq.sv
module microseq
    import useq_pkg::*;
#(
    parameter int UPC_W    = 8,
    parameter int LC_W     = 8,
    parameter int IR_W     = 16,
    parameter int OPC_W    = 4,
    parameter int MODE_LSB = 8,
    parameter int MODE_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [4:0]       seq_op_i,
    input  logic [UPC_W-1:0] br_addr_i,
    input  logic             flag_z_i,
    input  logic             flag_n_i,
    input  logic             flag_c_i,
    input  logic             flag_o_i,
    input  logic [IR_W-1:0]  ir_i,
    input  logic [1:0]       lc_op_i,
    input  logic [LC_W-1:0]  lc_const_i,
    input  logic [LC_W-1:0]  bus_i,
    input  logic             tbl_we_i,
    input  logic             tbl_sel_i,
    input  logic [OPC_W-1:0] tbl_idx_i,
    input  logic [UPC_W-1:0] tbl_data_i,
    output logic [UPC_W-1:0] upc_o,
    output logic             l_flag_o,
    output logic             halted_o
);
    localparam int OPC_LSB = IR_W - OPC_W;
    localparam logic [UPC_W-1:0] UPC_ONE = UPC_W'(1);

    seq_op_e          op;
    lc_op_e           lc_op;
    seq_flags_t       flags;
    logic [UPC_W-1:0] upc_q, ret_q, upc_d, ret_d, op_tgt, mode_tgt;
    logic             halted_q, halted_d, ret_we, lc_zero;

    assign op    = seq_op_e'(seq_op_i);
    assign lc_op = lc_op_e'(lc_op_i);
    assign flags = '{z: flag_z_i, n: flag_n_i, c: flag_c_i, o: flag_o_i, l: lc_zero};

    useq_dtable #(.IDX_W(OPC_W), .DATA_W(UPC_W)) u_optab (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we_i && !tbl_sel_i),
        .widx  (tbl_idx_i),
        .wdata (tbl_data_i),
        .ridx  (ir_i[OPC_LSB +: OPC_W]),
        .rdata (op_tgt)
    );

    useq_dtable #(.IDX_W(MODE_W), .DATA_W(UPC_W)) u_modetab (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we_i && tbl_sel_i),
        .widx  (tbl_idx_i[MODE_W-1:0]),
        .wdata (tbl_data_i),
        .ridx  (ir_i[MODE_LSB +: MODE_W]),
        .rdata (mode_tgt)
    );

    useq_loopctr #(.LC_W(LC_W)) u_lc (
        .clk   (clk),
        .rst   (rst),
        .en    (!halted_q),
        .op    (lc_op),
        .konst (lc_const_i),
        .bus   (bus_i),
        .zero  (lc_zero)
    );

    useq_nextaddr #(.UPC_W(UPC_W)) u_next (
        .op       (op),
        .flags    (flags),
        .halted   (halted_q),
        .start    (start_i),
        .upc      (upc_q),
        .ret_addr (ret_q),
        .br_addr  (br_addr_i),
        .op_tgt   (op_tgt),
        .mode_tgt (mode_tgt),
        .upc_d    (upc_d),
        .ret_we   (ret_we),
        .ret_d    (ret_d),
        .halted_d (halted_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upc_q    <= '0;
            ret_q    <= '0;
            halted_q <= 1'b0;
        end else begin
            upc_q    <= upc_d;
            halted_q <= halted_d;
            if (ret_we) ret_q <= ret_d;
        end
    end

    assign upc_o    = upc_q;
    assign l_flag_o = lc_zero;
    assign halted_o = halted_q;

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!halted_q && op == SQ_STEP) |=> upc_q == $past(upc_q) + UPC_ONE);

    assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (!halted_q && op == SQ_JUMP) |=> upc_q == $past(br_addr_i));

    assert_ret_only_call_R6: assert property (@(posedge clk) disable iff (rst)
        !(!halted_q && op == SQ_CALL) |=> $stable(ret_q));

    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (halted_q && !start_i) |=> (halted_q && upc_q == '0));

    assert_start_release_R8: assert property (@(posedge clk) disable iff (rst)
        (halted_q && start_i) |=> (!halted_q && upc_q == '0));

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (!halted_q && op == SQ_RESTART) |=> (!halted_q && upc_q == '0));

endmodule

// File: tb/microseq_tb.sv
module microseq_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [4:0] seq_op_i = '0;
    logic [7:0] br_addr_i = '0;
    logic       fz = 1'b0, fn = 1'b0, fc = 1'b0, fo = 1'b0;
    logic [15:0] ir_i = '0;
    logic [1:0] lc_op_i = '0;
    logic [7:0] lc_const_i = '0, bus_i = '0;
    logic       tbl_we_i = 1'b0, tbl_sel_i = 1'b0;
    logic [3:0] tbl_idx_i = '0;
    logic [7:0] tbl_data_i = '0;
    logic [7:0] upc_o;
    logic       l_flag_o, halted_o;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_upc, m_ret, m_lc;
    logic       m_halt;
    logic [7:0] m_op [16];
    logic [7:0] m_mode [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    microseq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .seq_op_i(seq_op_i),
        .br_addr_i(br_addr_i), .flag_z_i(fz), .flag_n_i(fn), .flag_c_i(fc),
        .flag_o_i(fo), .ir_i(ir_i), .lc_op_i(lc_op_i), .lc_const_i(lc_const_i),
        .bus_i(bus_i), .tbl_we_i(tbl_we_i), .tbl_sel_i(tbl_sel_i),
        .tbl_idx_i(tbl_idx_i), .tbl_data_i(tbl_data_i),
        .upc_o(upc_o), .l_flag_o(l_flag_o), .halted_o(halted_o)
    );

    function automatic string tag_of(input logic [4:0] op, input logic h);
        if (h) return "R7/R8";
        case (op)
            5'd1: return "R3";
            2,3,4,5,6,7,8,9: return "R4";
            10,11: return "R14";
            5'd12: return "R5";
            5'd13: return "R5/R6";
            5'd14: return "R10";
            5'd15: return "R11";
            5'd16: return "R7";
            5'd17: return "R9";
            default: return "R2";
        endcase
    endfunction

    // Reference model step, computed from the requirements.
    function automatic void model_step();
        logic [7:0] nu;
        logic       hit, sel, l;
        l  = (m_lc == 8'd0);
        nu = m_upc + 8'd1;
        if (m_halt) begin
            nu = 8'd0;
            if (start_i) m_halt = 1'b0;
        end else begin
            case (seq_op_i)
                5'd1: nu = br_addr_i;
                2,3,4,5,6,7,8,9,10,11: begin
                    case (seq_op_i[4:1])
                        4'd1: sel = fz;
                        4'd2: sel = fn;
                        4'd3: sel = fc;
                        4'd4: sel = fo;
                        default: sel = l;
                    endcase
                    hit = seq_op_i[0] ? !sel : sel;
                    if (hit) nu = br_addr_i;
                end
                5'd12: begin m_ret = m_upc + 8'd1; nu = br_addr_i; end
                5'd13: nu = m_ret;
                5'd14: nu = m_op[ir_i[15:12]];
                5'd15: nu = m_mode[ir_i[9:8]];
                5'd16: begin nu = 8'd0; m_halt = 1'b1; end
                5'd17: nu = 8'd0;
                default: ;
            endcase
            case (lc_op_i)
                2'd1: m_lc = lc_const_i;
                2'd2: m_lc = bus_i;
                2'd3: m_lc = m_lc - 8'd1;
                default: ;
            endcase
        end
        if (tbl_we_i) begin
            if (tbl_sel_i) m_mode[tbl_idx_i[1:0]] = tbl_data_i;
            else           m_op[tbl_idx_i] = tbl_data_i;
        end
        m_upc = nu;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (upc_o !== m_upc || l_flag_o !== (m_lc == 8'd0) || halted_o !== m_halt) begin
            errors++;
            $display("FAIL %s: got upc=%h l=%b halted=%b, expected upc=%h l=%b halted=%b",
                     tag, upc_o, l_flag_o, halted_o, m_upc, (m_lc == 8'd0), m_halt);
        end
    endtask

    // Inputs are set at a falling edge; results are sampled at the next falling edge.
    task automatic cycle();
        string tag;
        tag = tag_of(seq_op_i, m_halt);
        if (tbl_we_i) tag = {tag, "+R12"};
        if (lc_op_i != 2'd0) tag = {tag, "+R13"};
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        seq_op_i = 5'd0; lc_op_i = 2'd0; tbl_we_i = 1'b0; start_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        m_upc = '0; m_ret = '0; m_lc = '0; m_halt = 1'b0;
        for (int i = 0; i < 16; i++) m_op[i] = '0;
        for (int i = 0; i < 4; i++) m_mode[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1");

        // R1: tables come out of reset cleared
        seq_op_i = 5'd14; ir_i = 16'h7000; cycle();
        idle();

        // R12: load opcode table, then dispatch over every entry (R10)
        for (int i = 0; i < 16; i++) begin
            tbl_we_i = 1'b1; tbl_sel_i = 1'b0; tbl_idx_i = 4'(i);
            tbl_data_i = 8'(8'h40 + i * 5); cycle();
        end
        for (int k = 0; k < 4; k++) begin
            tbl_we_i = 1'b1; tbl_sel_i = 1'b1; tbl_idx_i = 4'(k + 4 * k);
            tbl_data_i = 8'(8'hA0 + k * 9); cycle();
        end
        tbl_we_i = 1'b0;
        for (int i = 0; i < 16; i++) begin
            seq_op_i = 5'd14; ir_i = {4'(i), 12'($urandom)}; cycle();
        end
        // R11: mode dispatch over every entry
        for (int k = 0; k < 4; k++) begin
            seq_op_i = 5'd15; ir_i = 16'($urandom);
            ir_i[9:8] = 2'(k); cycle();
        end
        // R12: write and dispatch in the same cycle reads the old entry
        seq_op_i = 5'd14; ir_i = 16'h5000;
        tbl_we_i = 1'b1; tbl_sel_i = 1'b0; tbl_idx_i = 4'd5; tbl_data_i = 8'h11;
        cycle();
        tbl_we_i = 1'b0; cycle();

        // R5/R6: call, step, return twice
        seq_op_i = 5'd1; br_addr_i = 8'h20; cycle();
        seq_op_i = 5'd12; br_addr_i = 8'h70; cycle();
        seq_op_i = 5'd0; cycle();
        seq_op_i = 5'd13; cycle();
        cycle();

        // R13/R14: counter 2,1,0 with L branches, wrap, bus load
        seq_op_i = 5'd0; lc_op_i = 2'd1; lc_const_i = 8'd2; cycle();
        lc_op_i = 2'd3; seq_op_i = 5'd10; br_addr_i = 8'h55; cycle();
        seq_op_i = 5'd10; cycle();
        lc_op_i = 2'd0; seq_op_i = 5'd10; cycle();
        seq_op_i = 5'd11; br_addr_i = 8'h66; cycle();
        lc_op_i = 2'd3; seq_op_i = 5'd0; cycle();
        lc_op_i = 2'd2; bus_i = 8'd0; cycle();
        // R4: each condition code with flags set then clear
        lc_op_i = 2'd0;
        for (int c = 2; c < 10; c++) begin
            for (int f = 0; f < 2; f++) begin
                seq_op_i = 5'(c); br_addr_i = 8'(8'h80 + c);
                {fz, fn, fc, fo} = f[0] ? 4'hF : 4'h0; cycle();
            end
        end

        // R7/R8: halt, ignored microwords and counter actions, then start
        seq_op_i = 5'd1; br_addr_i = 8'h33; cycle();
        seq_op_i = 5'd16; cycle();
        seq_op_i = 5'd1; br_addr_i = 8'h44; lc_op_i = 2'd3; cycle();
        seq_op_i = 5'd12; lc_op_i = 2'd1; lc_const_i = 8'd9; cycle();
        tbl_we_i = 1'b1; tbl_sel_i = 1'b1; tbl_idx_i = 4'd2; tbl_data_i = 8'hC3; cycle();
        tbl_we_i = 1'b0; lc_op_i = 2'd0; start_i = 1'b1; seq_op_i = 5'd1; cycle();
        start_i = 1'b0; seq_op_i = 5'd15; ir_i = 16'h0200; cycle();
        // R9: restart keeps running
        seq_op_i = 5'd17; cycle();
        seq_op_i = 5'd0; cycle();
        // R2: unassigned code steps
        seq_op_i = 5'd25; cycle();
        seq_op_i = 5'd1; br_addr_i = 8'hFF; cycle();
        seq_op_i = 5'd0; cycle();

        // Random mix
        for (int n = 0; n < 5000; n++) begin
            seq_op_i   = 5'($urandom_range(0, 31));
            br_addr_i  = 8'($urandom);
            {fz, fn, fc, fo} = 4'($urandom);
            ir_i       = 16'($urandom);
            lc_op_i    = 2'($urandom);
            lc_const_i = 8'($urandom_range(0, 3));
            bus_i      = 8'($urandom_range(0, 2));
            tbl_we_i   = ($urandom_range(0, 7) == 0);
            tbl_sel_i  = 1'($urandom);
            tbl_idx_i  = 4'($urandom);
            tbl_data_i = 8'($urandom);
            start_i    = ($urandom_range(0, 3) == 0);
            cycle();
        end
        idle();
        finish_run();
    end

endmodule